// File: doc/BRIEF.md
# General-Purpose Pin Port with Atomic Bit Controls

This block is a memory-mapped port of general-purpose pins for a system-on-chip. Each pin has an output value, an output-enable (direction) bit and an input-buffer enable. Software changes output values in two ways. It can assign the whole output word with one write. It can also use three write-one-to-act registers, which raise, drop or invert only the pins whose write bits are 1. Pins whose write bits are 0 keep their values, so no read-modify-write sequence is needed.

Each pin has a sensed level. For a pin configured as an output this is the value the port drives. For an input pin with its buffer enabled it is the pad level after a two-flop synchronizer. Otherwise it is 0. Each pin can request an interrupt from its sensed level, either while the level is high or when it sees an edge. Edge mode can watch the rising edge alone or both edges. A caught edge stays pending until software writes 1 to its bit. The interrupt enable is changed only through separate enable-set and enable-clear registers. The single interrupt output is high while any enabled pin has an active request. Because output pins are sensed from their driven value, software can raise an interrupt on such a pin by writing its data bit.

The register bus is a plain single-cycle write strobe with an address and write word. Read data is combinational from the address. Register select codes: 0 data (write assigns outputs, read returns the sensed levels), 1 set, 2 clear, 3 toggle, 4 direction, 5 input enable, 6 enable-set (read returns enables), 7 enable-clear (read returns enables), 8 edge select, 9 both-edge select, 10 pending (read pending, write 1 to clear), 11 output word readback. Reads of unused codes return 0.

Top module: `gpio_atomic_port`

## Requirements
- R1: After reset the outputs, output enables, input-buffer enables, interrupt enables, pending bits and the interrupt output are all 0.
- R2: A write to code 1 drives high every output whose write bit is 1 and leaves the others unchanged.
- R3: A write to code 2 drives low every output whose write bit is 1 and leaves the others unchanged.
- R4: A write to code 3 inverts every output whose write bit is 1 and leaves the others unchanged.
- R5: A write to code 0 assigns the whole output word. The registers at codes 4 and 5 appear directly on the output-enable and input-enable pins, where 1 means enabled.
- R6: A read of code 0 returns, per pin, the driven value when its direction bit is 1, the pad level when its direction bit is 0 and its input enable is 1 (visible from the second rising clock edge after the pad changes), and 0 otherwise.
- R7: Writing 1 to a bit at code 6 enables that pin's interrupt, writing 1 at code 7 disables it, and 0 bits change nothing. The current enables read back at code 6.
- R8: A pin whose code-8 bit is 0 is level sensitive: it requests an interrupt while its sensed level is 1, and the request ends when the level returns to 0.
- R9: A pin whose code-8 bit is 1 and code-9 bit is 0 sets its pending bit (read at code 10) on a rising sensed edge only.
- R10: A pin whose code-8 and code-9 bits are both 1 sets its pending bit on rising and falling sensed edges.
- R11: A pending bit stays set until a write to code 10 has a 1 in that bit. 0 bits in that write leave pending bits untouched. A new edge in the same cycle as the clearing write keeps the bit set.
- R12: An output pin in level mode with its interrupt enabled requests an interrupt when software drives its data bit to 1.
- R13: The interrupt output is the OR over pins of (enabled and requesting). A pending bit on a disabled pin stays visible at code 10 but does not raise the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 4 | Register select code |
| bus_wdata | input | NPINS | Write word |
| bus_rdata | output | NPINS | Read word for bus_addr, combinational |
| pin_in | input | NPINS | Pad input levels, asynchronous |
| pin_out | output | NPINS | Driven output values |
| pin_oe | output | NPINS | Output driver enables |
| pin_ie | output | NPINS | Input buffer enables |
| irq | output | 1 | Port interrupt request |

## Verification
The assertions assume a single write strobe per cycle, so at most one of the set, clear, toggle and data actions can act in any cycle. They also assume that the pad inputs may change at any time, since the synchronizer absorbs them. The stimulus changes the bus and the pads only on falling clock edges. It holds each pad change for at least four cycles before sampling, which leaves time for the synchronizer and the edge latch. Edge and level modes are programmed only on pins whose sensed level is already stable, so reconfiguration does not latch stray edges.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
  localparam int unsigned SEL_W = 4;

  typedef enum logic [SEL_W-1:0] {
    SEL_DATA  = 4'd0,
    SEL_SET   = 4'd1,
    SEL_CLR   = 4'd2,
    SEL_TGL   = 4'd3,
    SEL_DIR   = 4'd4,
    SEL_INEN  = 4'd5,
    SEL_MSET  = 4'd6,
    SEL_MCLR  = 4'd7,
    SEL_EDGE  = 4'd8,
    SEL_BOTH  = 4'd9,
    SEL_PEND  = 4'd10,
    SEL_OUTV  = 4'd11
  } reg_sel_e;

  typedef struct packed {
    logic data;
    logic set;
    logic clr;
    logic tgl;
    logic dir;
    logic inen;
    logic mset;
    logic mclr;
    logic edge_sel;
    logic both;
    logic pclr;
  } wr_strobe_t;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] sync_out
);
  logic [W-1:0] stage1_q;
  logic [W-1:0] stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= '0;
      stage2_q <= '0;
    end else begin
      stage1_q <= async_in;
      stage2_q <= stage1_q;
    end
  end

  assign sync_out = stage2_q;
endmodule

// File: rtl/gpio_out_regs.sv
module gpio_out_regs
  import gpio_port_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  wr_strobe_t   st,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] out_q,
  output logic [W-1:0] dir_q,
  output logic [W-1:0] inen_q
);
  // Next output word; clear is applied after set so clear dominates a shared bit.
  function automatic logic [W-1:0] next_out(
    input logic [W-1:0] cur,
    input logic [W-1:0] w,
    input wr_strobe_t   s
  );
    logic [W-1:0] v;
    if (s.data) begin
      v = w;
    end else begin
      v = cur | (s.set ? w : '0);
      v = v & ~(s.clr ? w : '0);
      v = v ^ (s.tgl ? w : '0);
    end
    return v;
  endfunction

  logic [W-1:0] out_nxt;
  assign out_nxt = next_out(out_q, wdata, st);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q  <= '0;
      dir_q  <= '0;
      inen_q <= '0;
    end else begin
      out_q <= out_nxt;
      if (st.dir)  dir_q  <= wdata;
      if (st.inen) inen_q <= wdata;
    end
  end

  AST_SET_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    st.set |=> ((out_q & $past(wdata)) == $past(wdata))); // R2
  AST_SET_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    st.set |=> ((out_q & ~$past(wdata)) == ($past(out_q) & ~$past(wdata)))); // R2
  AST_CLR_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    st.clr |=> ((out_q & $past(wdata)) == '0)); // R3
  AST_TGL_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
    st.tgl |=> (out_q == ($past(out_q) ^ $past(wdata)))); // R4
  AST_DATA_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    st.data |=> (out_q == $past(wdata))); // R5
endmodule

// File: rtl/gpio_irq_unit.sv
module gpio_irq_unit
  import gpio_port_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  wr_strobe_t   st,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] sensed,
  output logic [W-1:0] mask_q,
  output logic [W-1:0] edge_q,
  output logic [W-1:0] both_q,
  output logic [W-1:0] pend_q,
  output logic         irq
);
  // Edge hits: rising always, falling only where both-edge is selected.
  function automatic logic [W-1:0] edge_hits(
    input logic [W-1:0] cur,
    input logic [W-1:0] prev,
    input logic [W-1:0] both
  );
    return (cur & ~prev) | (both & ~cur & prev);
  endfunction

  logic [W-1:0] prev_q;
  logic [W-1:0] edge_ev;
  logic [W-1:0] level_req;
  logic [W-1:0] active;
  logic [W-1:0] pend_nxt;
  logic [W-1:0] mask_nxt;

  assign edge_ev   = edge_hits(sensed, prev_q, both_q) & edge_q;
  assign level_req = sensed & ~edge_q;
  assign pend_nxt  = (pend_q & ~(st.pclr ? wdata : '0)) | edge_ev;
  assign mask_nxt  = (mask_q | (st.mset ? wdata : '0)) & ~(st.mclr ? wdata : '0);
  assign active    = (level_req | pend_q) & mask_q;
  assign irq       = |active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      mask_q <= '0;
      edge_q <= '0;
      both_q <= '0;
      pend_q <= '0;
    end else begin
      prev_q <= sensed;
      mask_q <= mask_nxt;
      pend_q <= pend_nxt;
      if (st.edge_sel) edge_q <= wdata;
      if (st.both)     both_q <= wdata;
    end
  end

  AST_MASK_SET: assert property (@(posedge clk) disable iff (!rst_n)
    st.mset |=> ((mask_q & $past(wdata)) == $past(wdata))); // R7
  AST_MASK_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    st.mclr |=> ((mask_q & $past(wdata)) == '0)); // R7
  AST_PEND_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !st.pclr |=> ((pend_q & $past(pend_q)) == $past(pend_q))); // R11
  AST_EDGE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (|edge_ev) |=> ((pend_q & $past(edge_ev)) == $past(edge_ev))); // R11
  AST_NO_FALL_RISE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    ((edge_ev & ~both_q & ~sensed) == '0)); // R9
endmodule

// File: rtl/gpio_atomic_port.sv
module gpio_atomic_port
  import gpio_port_pkg::*;
#(
  parameter int unsigned NPINS = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     bus_wr,
  input  logic [SEL_W-1:0]         bus_addr,
  input  logic [NPINS-1:0]         bus_wdata,
  output logic [NPINS-1:0]         bus_rdata,
  input  logic [NPINS-1:0]         pin_in,
  output logic [NPINS-1:0]         pin_out,
  output logic [NPINS-1:0]         pin_oe,
  output logic [NPINS-1:0]         pin_ie,
  output logic                     irq
);
  wr_strobe_t       st;
  logic [NPINS-1:0] sync_in;
  logic [NPINS-1:0] out_q, dir_q, inen_q;
  logic [NPINS-1:0] mask_q, edge_q, both_q, pend_q;
  logic [NPINS-1:0] sensed;

  // Sensed level per pin: driven value for outputs, synchronized pad for enabled inputs.
  function automatic logic [NPINS-1:0] sense_level(
    input logic [NPINS-1:0] dir,
    input logic [NPINS-1:0] drv,
    input logic [NPINS-1:0] ien,
    input logic [NPINS-1:0] pad
  );
    return (dir & drv) | (~dir & ien & pad);
  endfunction

  always_comb begin
    st          = '0;
    st.data     = bus_wr && (bus_addr == SEL_DATA);
    st.set      = bus_wr && (bus_addr == SEL_SET);
    st.clr      = bus_wr && (bus_addr == SEL_CLR);
    st.tgl      = bus_wr && (bus_addr == SEL_TGL);
    st.dir      = bus_wr && (bus_addr == SEL_DIR);
    st.inen     = bus_wr && (bus_addr == SEL_INEN);
    st.mset     = bus_wr && (bus_addr == SEL_MSET);
    st.mclr     = bus_wr && (bus_addr == SEL_MCLR);
    st.edge_sel = bus_wr && (bus_addr == SEL_EDGE);
    st.both     = bus_wr && (bus_addr == SEL_BOTH);
    st.pclr     = bus_wr && (bus_addr == SEL_PEND);
  end

  gpio_sync #(.W(NPINS)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (pin_in),
    .sync_out (sync_in)
  );

  gpio_out_regs #(.W(NPINS)) u_out (
    .clk    (clk),
    .rst_n  (rst_n),
    .st     (st),
    .wdata  (bus_wdata),
    .out_q  (out_q),
    .dir_q  (dir_q),
    .inen_q (inen_q)
  );

  assign sensed = sense_level(dir_q, out_q, inen_q, sync_in);

  gpio_irq_unit #(.W(NPINS)) u_irq (
    .clk    (clk),
    .rst_n  (rst_n),
    .st     (st),
    .wdata  (bus_wdata),
    .sensed (sensed),
    .mask_q (mask_q),
    .edge_q (edge_q),
    .both_q (both_q),
    .pend_q (pend_q),
    .irq    (irq)
  );

  always_comb begin
    case (bus_addr)
      SEL_DATA: bus_rdata = sensed;
      SEL_DIR:  bus_rdata = dir_q;
      SEL_INEN: bus_rdata = inen_q;
      SEL_MSET: bus_rdata = mask_q;
      SEL_MCLR: bus_rdata = mask_q;
      SEL_EDGE: bus_rdata = edge_q;
      SEL_BOTH: bus_rdata = both_q;
      SEL_PEND: bus_rdata = pend_q;
      SEL_OUTV: bus_rdata = out_q;
      default:  bus_rdata = '0;
    endcase
  end

  assign pin_out = out_q;
  assign pin_oe  = dir_q;
  assign pin_ie  = inen_q;

  AST_IRQ_NEEDS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == '0) |-> !irq); // R13
  AST_IRQ_NEEDS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    ((sensed == '0) && (pend_q == '0)) |-> !irq); // R13
  AST_SENSE_UNDRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
    ((sensed & ~dir_q & ~inen_q) == '0)); // R6
endmodule

// File: tb/sim_gpio_atomic_port.sv
module sim_gpio_atomic_port;
  localparam int NP = 16;
  localparam int K_RD = 0, K_OUT = 1, K_OE = 2, K_IE = 3, K_IRQ = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bus_wr = 1'b0;
  logic [3:0]    bus_addr = '0;
  logic [NP-1:0] bus_wdata = '0;
  logic [NP-1:0] bus_rdata;
  logic [NP-1:0] pin_in = '0;
  logic [NP-1:0] pin_out, pin_oe, pin_ie;
  logic          irq;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  typedef struct {
    int          kind;
    logic [15:0] exp;
    string       tag;
  } item_t;
  item_t sb[$];

  logic [NP-1:0] m_out = '0;  // bench's own output word

  always #10 clk = ~clk;  // 50 MHz

  gpio_atomic_port #(.NPINS(NP)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .pin_ie(pin_ie), .irq(irq)
  );

  task automatic wr(input logic [3:0] a, input logic [NP-1:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic expect_item(input int kind, input logic [3:0] a,
                             input logic [15:0] e, input string tag);
    item_t it;
    @(negedge clk);
    bus_addr = a;
    it.kind = kind; it.exp = e; it.tag = tag;
    sb.push_back(it);
    wait (sb.size() == 0);
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  // Monitor: pops expected items and compares them with what the design shows.
  initial begin
    forever begin
      @(posedge clk);
      #5;
      if (sb.size() > 0) begin
        item_t it;
        logic [15:0] got;
        it = sb.pop_front();
        case (it.kind)
          K_RD:    got = bus_rdata;
          K_OUT:   got = pin_out;
          K_OE:    got = pin_oe;
          K_IE:    got = pin_ie;
          default: got = {15'd0, irq};
        endcase
        total++;
        if (got !== it.exp) begin
          bad++;
          $display("FAIL %s: got=%h expected=%h", it.tag, got, it.exp);
        end
      end
    end
  end

  initial begin
    #(20 * 20000);
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL watchdog: got=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    expect_item(K_OUT, 4'd0, 16'h0000, "R1 pin_out");
    expect_item(K_OE,  4'd0, 16'h0000, "R1 pin_oe");
    expect_item(K_IE,  4'd0, 16'h0000, "R1 pin_ie");
    expect_item(K_IRQ, 4'd0, 16'h0000, "R1 irq");
    expect_item(K_RD,  4'd6, 16'h0000, "R1 enables");
    expect_item(K_RD,  4'd10, 16'h0000, "R1 pending");

    // R5 whole-word write
    m_out = 16'hA5A5; wr(4'd0, 16'hA5A5);
    expect_item(K_OUT, 4'd0, m_out, "R5 data write");
    // R2 set
    m_out = m_out | 16'h00F0; wr(4'd1, 16'h00F0);
    expect_item(K_OUT, 4'd0, m_out, "R2 set");
    // R3 clear
    m_out = m_out & ~16'h0005; wr(4'd2, 16'h0005);
    expect_item(K_OUT, 4'd0, m_out, "R3 clear");
    // R4 toggle
    m_out = m_out ^ 16'hFF00; wr(4'd3, 16'hFF00);
    expect_item(K_OUT, 4'd0, m_out, "R4 toggle");
    expect_item(K_RD, 4'd11, m_out, "R4 readback");
    // R5 direction and input enables
    wr(4'd4, 16'h00FF);
    expect_item(K_OE, 4'd0, 16'h00FF, "R5 pin_oe");
    wr(4'd5, 16'hFF00);
    expect_item(K_IE, 4'd0, 16'hFF00, "R5 pin_ie");

    // R6 sensed levels
    pin_in = 16'h3C3C;
    settle();
    expect_item(K_RD, 4'd0, (m_out & 16'h00FF) | (16'h3C3C & 16'hFF00), "R6 sensed");

    // R8 level interrupt on pin 8
    wr(4'd6, 16'h0100);
    expect_item(K_RD, 4'd6, 16'h0100, "R7 enable set");
    expect_item(K_IRQ, 4'd0, 16'h0000, "R8 level low");
    pin_in[8] = 1'b1; settle();
    expect_item(K_IRQ, 4'd0, 16'h0001, "R8 level high");
    pin_in[8] = 1'b0; settle();
    expect_item(K_IRQ, 4'd0, 16'h0000, "R8 level gone");
    wr(4'd7, 16'h0100);
    expect_item(K_RD, 4'd6, 16'h0000, "R7 enable clear");

    // R9 rising edge only on pin 9
    wr(4'd8, 16'h0200);
    wr(4'd6, 16'h0200);
    pin_in[9] = 1'b1; settle();
    expect_item(K_RD, 4'd10, 16'h0200, "R9 rise pending");
    expect_item(K_IRQ, 4'd0, 16'h0001, "R9 irq");
    wr(4'd10, 16'h0200);
    expect_item(K_IRQ, 4'd0, 16'h0000, "R11 cleared");
    pin_in[9] = 1'b0; settle();
    expect_item(K_RD, 4'd10, 16'h0000, "R9 fall ignored");

    // R10 both edges
    wr(4'd9, 16'h0200);
    pin_in[9] = 1'b1; settle();
    expect_item(K_RD, 4'd10, 16'h0200, "R10 rise");
    wr(4'd10, 16'h0200);
    pin_in[9] = 1'b0; settle();
    expect_item(K_RD, 4'd10, 16'h0200, "R10 fall");
    wr(4'd10, 16'h0000);
    expect_item(K_RD, 4'd10, 16'h0200, "R11 zero write keeps");
    wr(4'd10, 16'hFFFF);
    expect_item(K_RD, 4'd10, 16'h0000, "R11 clear all");
    wr(4'd7, 16'h0200);

    // R13 disabled pending stays visible, no irq
    wr(4'd8, 16'h4200);
    wr(4'd9, 16'h0000);
    pin_in[14] = 1'b1; settle();
    expect_item(K_RD, 4'd10, 16'h4000, "R13 pending visible");
    expect_item(K_IRQ, 4'd0, 16'h0000, "R13 masked quiet");
    wr(4'd6, 16'h4000);
    expect_item(K_IRQ, 4'd0, 16'h0001, "R13 enabled fires");
    wr(4'd10, 16'h4000);
    expect_item(K_IRQ, 4'd0, 16'h0000, "R13 after clear");
    wr(4'd7, 16'h4000);

    // R12 software interrupt on output pin 0 (level mode)
    wr(4'd6, 16'h0001);
    expect_item(K_IRQ, 4'd0, 16'h0000, "R12 idle");
    m_out = m_out | 16'h0001; wr(4'd1, 16'h0001);
    expect_item(K_IRQ, 4'd0, 16'h0001, "R12 software raise");
    m_out = m_out & ~16'h0001; wr(4'd2, 16'h0001);
    expect_item(K_IRQ, 4'd0, 16'h0000, "R12 software drop");
    expect_item(K_OUT, 4'd0, m_out, "R3 final word");

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule